// File: doc/BRIEF.md
# Fine-Tuning NCO Complex Modulator

This block shifts a complex baseband transmit stream (I and Q samples) up or down in frequency by a programmable amount. A 26-bit phase accumulator advances by a signed tuning word on every accepted sample. The top bits of the phase address a quarter-wave sine/cosine table, and a complex multiplier rotates each sample by the current phase. The frequency step is therefore the sample rate divided by 2^26. A positive word rotates toward positive frequencies and a negative word toward negative ones.

The modulator only acts when the enable is high and the interpolation-mode input selects 4x. In every other setting each sample is passed through bit-exact with the same latency, and the accumulator is held at zero.

Samples enter and leave on valid/ready streams. A sample is taken on an input edge where `in_valid` and `in_ready` are both high, and it leaves on an output edge where `out_valid` and `out_ready` are both high. The pipeline stalls as a whole when the output is held. `in_ready` is low exactly while a result waits on a low `out_ready`, and the output value stays frozen for that time. The input may present data in any cycle, and the tuning word may change between any two samples.

Top module: `fine_nco_mod`

## Requirements
- R1: Stream rules. While `out_valid` is high and `out_ready` is low, `in_ready` is low and `out_valid`, `out_i` and `out_q` hold their values into the next cycle. Every accepted sample yields exactly one output, in order.
- R2: With `out_ready` held high, a sample accepted on clock edge E is presented with `out_valid` high after edge E+3, and `out_valid` is low after edges E+1 and E+2 when no other sample is in flight.
- R3: With `en` low, each output equals its input sample exactly.
- R4: With `en` high and `interp_mode` not equal to 2'b10 (2'b00 = 1x, 2'b01 = 2x, 2'b11 = reserved), each output equals its input sample exactly. Only 2'b10 (4x) activates rotation.
- R5: Active with a zero tuning word, each output is within 1 LSB of its input.
- R6: Active, sample n after activation is rotated by the angle 2π·P/1024. P is the top 10 bits of the phase p_n, where p_0 = 0 and p_(n+1) = p_n + ftw mod 2^26. Outputs are I·cos − Q·sin and I·sin + Q·cos, each within 3 LSB of the ideal rounded value.
- R7: A negative (two's complement) tuning word rotates in the negative direction, following the same phase rule as R6.
- R8: A new tuning word first changes the phase step that follows the next accepted sample. The phase carries on from its current value with no jump.
- R9: Whenever the block is inactive (`en` low or mode not 4x), the phase accumulator returns to zero. The first sample after reactivation uses phase 0.
- R10: Results outside the 14-bit signed range saturate to 8191 or −8192.
- R11: During and right after reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Modulator enable |
| interp_mode | input | 2 | Interpolation setting; 2'b10 (4x) is the only one that allows rotation |
| ftw | input | 26 | Signed frequency tuning word, step = fs/2^26 |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Block can take a sample this cycle |
| in_i | input | 14 | Input I, signed |
| in_q | input | 14 | Input Q, signed |
| out_valid | output | 1 | Output sample valid |
| out_ready | input | 1 | Downstream takes the output this cycle |
| out_i | output | 14 | Output I, signed |
| out_q | output | 14 | Output Q, signed |

## Verification
The assertions check on every cycle the stream rules: a held output stays frozen and `in_ready` drops while the output is stalled. They also check the four-stage latency under free flow and the bit-exact pass-through of samples accepted while inactive. The bench scenarios cover the numeric behaviour. This includes the rotation angle against the accumulated phase for positive, negative and changing tuning words, and the return of the phase to zero after deactivation. It also includes saturation at full scale and the ordering of results under random back-pressure.

// File: rtl/fnco_pkg.sv
package fnco_pkg;
  localparam int unsigned FNCO_PW = 26;  // phase accumulator width
  localparam int unsigned FNCO_DW = 14;  // sample and amplitude width
  localparam int unsigned FNCO_LB = 10;  // phase bits used for the table

  typedef enum logic [1:0] {
    INTERP_1X  = 2'b00,
    INTERP_2X  = 2'b01,
    INTERP_4X  = 2'b10,
    INTERP_RSV = 2'b11
  } interp_e;
endpackage

// File: rtl/fnco_phase_acc.sv
module fnco_phase_acc #(
  parameter int unsigned PW = 26
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          step,
  input  logic [PW-1:0] ftw,
  output logic [PW-1:0] phase
);
  logic [PW-1:0] acc_q;

  // Modulo 2^PW wrap comes from the fixed width; a signed word wraps backwards.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    acc_q <= '0;
    else if (clr)  acc_q <= '0;
    else if (step) acc_q <= acc_q + ftw;
  end

  assign phase = acc_q;
endmodule

// File: rtl/fnco_sincos.sv
module fnco_sincos #(
  parameter int unsigned LB = 10,
  parameter int unsigned DW = 14
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ce,
  input  logic [LB-1:0]        idx,
  output logic signed [DW-1:0] cos_o,
  output logic signed [DW-1:0] sin_o
);
  localparam int unsigned QB  = LB - 2;
  localparam int unsigned QN  = 1 << QB;
  localparam real         AMP = (2.0 ** (DW - 1)) - 1.0;
  localparam real         TAU = 6.283185307179586;

  // Quarter wave, QN+1 points so that both 0 and the peak are exact.
  logic signed [DW-1:0] qtab [0:QN];

  for (genvar k = 0; k <= QN; k++) begin : g_tab
    localparam int VAL = $rtoi($sin(TAU * k / (4.0 * QN)) * AMP + 0.5);
    assign qtab[k] = VAL[DW-1:0];
  end

  logic [1:0]           quad;
  logic [QB:0]          ka, kb;
  logic signed [DW-1:0] ta, tb, c_d, s_d;

  always_comb begin
    quad = idx[LB-1 -: 2];
    ka   = {1'b0, idx[QB-1:0]};
    kb   = (QB+1)'(QN) - ka;
    ta   = qtab[ka];
    tb   = qtab[kb];
    unique case (quad)
      2'd0:    begin s_d =  ta; c_d =  tb; end
      2'd1:    begin s_d =  tb; c_d = -ta; end
      2'd2:    begin s_d = -ta; c_d = -tb; end
      default: begin s_d = -tb; c_d =  ta; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cos_o <= '0;
      sin_o <= '0;
    end else if (ce) begin
      cos_o <= c_d;
      sin_o <= s_d;
    end
  end
endmodule

// File: rtl/fnco_cmul.sv
module fnco_cmul #(
  parameter int unsigned DW = 14
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ce,
  input  logic                 act,
  input  logic signed [DW-1:0] di,
  input  logic signed [DW-1:0] dq,
  input  logic signed [DW-1:0] c,
  input  logic signed [DW-1:0] s,
  output logic signed [DW-1:0] yi,
  output logic signed [DW-1:0] yq
);
  localparam int unsigned PWD = 2 * DW;
  localparam int unsigned SW  = PWD + 1;
  localparam logic signed [SW-1:0] HALF = SW'(1) << (DW - 2);
  localparam logic signed [SW-1:0] HI   = SW'((1 << (DW - 1)) - 1);
  localparam logic signed [SW-1:0] LO   = ~HI;

  logic signed [PWD-1:0] p_ic, p_qs, p_is, p_qc;
  logic                  act_r;
  logic signed [DW-1:0]  di_r, dq_r;

  function automatic logic signed [DW-1:0] fold(input logic signed [SW-1:0] v);
    logic signed [SW-1:0] r;
    r = (v + HALF) >>> (DW - 1);
    if (r > HI)      return HI[DW-1:0];
    else if (r < LO) return LO[DW-1:0];
    else             return r[DW-1:0];
  endfunction

  logic signed [SW-1:0] sum_i, sum_q;
  always_comb begin
    sum_i = {p_ic[PWD-1], p_ic} - {p_qs[PWD-1], p_qs};
    sum_q = {p_is[PWD-1], p_is} + {p_qc[PWD-1], p_qc};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_ic <= '0; p_qs <= '0; p_is <= '0; p_qc <= '0;
      act_r <= 1'b0; di_r <= '0; dq_r <= '0;
      yi <= '0; yq <= '0;
    end else if (ce) begin
      p_ic  <= di * c;
      p_qs  <= dq * s;
      p_is  <= di * s;
      p_qc  <= dq * c;
      act_r <= act;
      di_r  <= di;
      dq_r  <= dq;
      yi    <= act_r ? fold(sum_i) : di_r;
      yq    <= act_r ? fold(sum_q) : dq_r;
    end
  end
endmodule

// File: rtl/fine_nco_mod.sv
module fine_nco_mod
  import fnco_pkg::*;
#(
  parameter int unsigned PW = FNCO_PW,
  parameter int unsigned DW = FNCO_DW,
  parameter int unsigned LB = FNCO_LB
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic [1:0]           interp_mode,
  input  logic [PW-1:0]        ftw,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic signed [DW-1:0] in_i,
  input  logic signed [DW-1:0] in_q,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic signed [DW-1:0] out_i,
  output logic signed [DW-1:0] out_q
);
  logic adv, fire, act;
  logic [PW-1:0] phase;

  // Whole pipeline moves together; it only stops when a result is held.
  assign adv      = !out_valid || out_ready;
  assign in_ready = adv;
  assign fire     = in_valid && adv;
  assign act      = en && (interp_mode == INTERP_4X);

  fnco_phase_acc #(.PW(PW)) u_acc (
    .clk(clk), .rst_n(rst_n), .clr(!act), .step(fire), .ftw(ftw), .phase(phase)
  );

  // Stage 0: capture sample, its mode and its phase.
  logic                 v0, act0;
  logic signed [DW-1:0] i0, q0;
  logic [LB-1:0]        ph0;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v0 <= 1'b0; act0 <= 1'b0; i0 <= '0; q0 <= '0; ph0 <= '0;
    end else if (adv) begin
      v0   <= in_valid;
      act0 <= act;
      i0   <= in_i;
      q0   <= in_q;
      ph0  <= phase[PW-1 -: LB];
    end
  end

  // Stage 1: table lookup, sample carried alongside.
  logic signed [DW-1:0] c1, s1, i1, q1;
  logic                 v1, act1;
  fnco_sincos #(.LB(LB), .DW(DW)) u_trig (
    .clk(clk), .rst_n(rst_n), .ce(adv), .idx(ph0), .cos_o(c1), .sin_o(s1)
  );
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1 <= 1'b0; act1 <= 1'b0; i1 <= '0; q1 <= '0;
    end else if (adv) begin
      v1 <= v0; act1 <= act0; i1 <= i0; q1 <= q0;
    end
  end

  // Stages 2 and 3: products, then round, saturate or pass through.
  fnco_cmul #(.DW(DW)) u_mul (
    .clk(clk), .rst_n(rst_n), .ce(adv), .act(act1),
    .di(i1), .dq(q1), .c(c1), .s(s1), .yi(out_i), .yq(out_q)
  );

  logic v2;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v2 <= 1'b0; out_valid <= 1'b0;
    end else if (adv) begin
      v2 <= v1; out_valid <= v2;
    end
  end
endmodule

// File: rtl/fnco_chk.sv
module fnco_chk #(
  parameter int unsigned PW = 26,
  parameter int unsigned DW = 14
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 en,
  input logic [1:0]           interp_mode,
  input logic [PW-1:0]        ftw,
  input logic                 in_valid,
  input logic                 in_ready,
  input logic signed [DW-1:0] in_i,
  input logic signed [DW-1:0] in_q,
  input logic                 out_valid,
  input logic                 out_ready,
  input logic signed [DW-1:0] out_i,
  input logic signed [DW-1:0] out_q
);
  logic [2:0] warm;
  logic       warm_ok, fire, idle_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           warm <= '0;
    else if (warm != 3'd4) warm <= warm + 3'd1;
  end
  assign warm_ok = (warm == 3'd4);
  assign fire    = in_valid && in_ready;
  assign idle_in = !(en && interp_mode == 2'b10);

  logic unused_ok;
  assign unused_ok = ^ftw;

  assert_stall_blocks_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  assert_stall_holds_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_i) && $stable(out_q)));

  assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_ok && $past(fire, 4) && $past(out_ready, 3) && $past(out_ready, 2)
     && $past(out_ready, 1)) |-> out_valid);

  assert_bypass_exact_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_ok && $past(fire, 4) && $past(idle_in, 4) && $past(out_ready, 3)
     && $past(out_ready, 2) && $past(out_ready, 1))
    |-> (out_i == $past(in_i, 4) && out_q == $past(in_q, 4)));
endmodule

bind fine_nco_mod fnco_chk #(.PW(PW), .DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .en(en), .interp_mode(interp_mode), .ftw(ftw),
  .in_valid(in_valid), .in_ready(in_ready), .in_i(in_i), .in_q(in_q),
  .out_valid(out_valid), .out_ready(out_ready), .out_i(out_i), .out_q(out_q)
);

// File: tb/fine_nco_mod_tb_top.sv
module fine_nco_mod_tb_top;
  localparam int PW = 26;
  localparam int DW = 14;
  localparam real TAU = 6.283185307179586;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic [1:0] interp_mode = 2'b00;
  logic [PW-1:0] ftw = '0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic signed [DW-1:0] in_i = '0, in_q = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic signed [DW-1:0] out_i, out_q;

  always #5 clk = ~clk;

  fine_nco_mod dut_i (
    .clk(clk), .rst_n(rst_n), .en(en), .interp_mode(interp_mode), .ftw(ftw),
    .in_valid(in_valid), .in_ready(in_ready), .in_i(in_i), .in_q(in_q),
    .out_valid(out_valid), .out_ready(out_ready), .out_i(out_i), .out_q(out_q)
  );

  int checks = 0;
  int errors = 0;
  int exp_i[$], exp_q[$], exp_tol[$];
  string exp_req[$];
  logic [PW-1:0] m_acc = '0;
  bit m_act = 1'b0;
  int ready_mode = 0; // 0 always, 1 random, 2 held low

  task automatic check(input string req, input int act, input int exp, input int tol);
    int d;
    checks++;
    d = act - exp;
    if (d < 0) d = -d;
    if (d > tol) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int sat14(input int v);
    if (v > 8191) return 8191;
    if (v < -8192) return -8192;
    return v;
  endfunction

  task automatic push_exp(input int di, input int dq, input int tol, input string req);
    int idx;
    real a, ri, rq;
    if (m_act) begin
      idx = int'(m_acc[PW-1 -: 10]);
      a = TAU * idx / 1024.0;
      ri = di * $cos(a) - dq * $sin(a);
      rq = di * $sin(a) + dq * $cos(a);
      exp_i.push_back(sat14($rtoi($floor(ri + 0.5))));
      exp_q.push_back(sat14($rtoi($floor(rq + 0.5))));
      exp_tol.push_back(tol);
      m_acc = m_acc + ftw;
    end else begin
      exp_i.push_back(di);
      exp_q.push_back(dq);
      exp_tol.push_back(0);
    end
    exp_req.push_back(req);
  endtask

  task automatic set_cfg(input bit e, input logic [1:0] m, input logic [PW-1:0] f);
    @(negedge clk);
    in_valid = 1'b0;
    en = e; interp_mode = m; ftw = f;
    m_act = e && (m == 2'b10);
    if (!m_act) m_acc = '0;
  endtask

  task automatic send(input int di, input int dq, input int tol, input string req);
    @(negedge clk);
    in_valid = 1'b1;
    in_i = DW'(di);
    in_q = DW'(dq);
    forever begin
      #1;
      if (in_ready) break;
      @(negedge clk);
    end
    push_exp(di, dq, tol, req);
    @(posedge clk);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic drain();
    for (int n = 0; n < 2000 && exp_i.size() != 0; n++) @(negedge clk);
    check("R1 drained", exp_i.size(), 0, 0);
  endtask

  function automatic int rnd_amp(input int lim);
    return int'($urandom_range(2 * lim)) - lim;
  endfunction

  // Monitor: sets out_ready each cycle and scores transfers.
  initial begin
    forever begin
      @(negedge clk);
      case (ready_mode)
        0: out_ready = 1'b1;
        1: out_ready = ($urandom_range(3) != 0);
        default: out_ready = 1'b0;
      endcase
      #1;
      if (rst_n && out_valid && out_ready) begin
        if (exp_i.size() == 0) begin
          checks++; errors++;
          $display("FAIL R1 actual unexpected output expected none");
        end else begin
          string r;
          int t;
          r = exp_req.pop_front();
          t = exp_tol.pop_front();
          check(r, int'(out_i), exp_i.pop_front(), t);
          check(r, int'(out_q), exp_q.pop_front(), t);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R1 watchdog actual hung expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R11 reset state
    repeat (3) @(negedge clk);
    check("R11 out_valid in reset", int'(out_valid), 0, 0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check("R11 out_valid after reset", int'(out_valid), 0, 0);
    check("R11 in_ready after reset", int'(in_ready), 1, 0);

    // R3 disabled: exact pass-through under random back-pressure
    ready_mode = 1;
    set_cfg(1'b0, 2'b10, 26'd1 << 20);
    for (int n = 0; n < 40; n++) send(rnd_amp(8000), rnd_amp(8000), 0, "R3 bypass disabled");
    idle(); drain();

    // R4 enabled but not 4x
    set_cfg(1'b1, 2'b00, 26'd1 << 21);
    for (int n = 0; n < 15; n++) send(rnd_amp(8192 - 1), rnd_amp(8000), 0, "R4 bypass 1x");
    set_cfg(1'b1, 2'b01, 26'd1 << 21);
    for (int n = 0; n < 15; n++) send(rnd_amp(8000), rnd_amp(8000), 0, "R4 bypass 2x");
    set_cfg(1'b1, 2'b11, 26'd1 << 21);
    for (int n = 0; n < 15; n++) send(rnd_amp(8000), rnd_amp(8000), 0, "R4 bypass reserved");
    idle(); drain();

    // R2 latency with free flow
    ready_mode = 0;
    set_cfg(1'b0, 2'b00, '0);
    send(1234, -567, 0, "R2 latency data");
    idle();
    @(negedge clk); #1; check("R2 not valid after E+1", int'(out_valid), 0, 0);
    @(negedge clk); #1; check("R2 not valid after E+2", int'(out_valid), 0, 0);
    @(negedge clk); #1; check("R2 valid after E+3", int'(out_valid), 1, 0);
    drain();

    // R5 zero tuning word
    ready_mode = 1;
    set_cfg(1'b1, 2'b10, '0);
    for (int n = 0; n < 30; n++) send(rnd_amp(8000), rnd_amp(8000), 1, "R5 zero word");
    idle(); drain();

    // R6 positive rotation
    set_cfg(1'b0, 2'b10, '0);
    set_cfg(1'b1, 2'b10, 26'd1 << 20);
    for (int n = 0; n < 80; n++) send(rnd_amp(5000), rnd_amp(5000), 3, "R6 positive rotation");
    idle(); drain();

    // R7 negative rotation, odd step so low bits matter
    set_cfg(1'b0, 2'b10, '0);
    set_cfg(1'b1, 2'b10, -26'sd314159);
    for (int n = 0; n < 80; n++) send(rnd_amp(5000), rnd_amp(5000), 3, "R7 negative rotation");
    idle(); drain();

    // R8 word changes mid-stream, phase continuous
    set_cfg(1'b1, 2'b10, 26'd777777);
    for (int n = 0; n < 20; n++) send(rnd_amp(5000), rnd_amp(5000), 3, "R8 before change");
    set_cfg(1'b1, 2'b10, -26'sd2000000);
    for (int n = 0; n < 20; n++) send(rnd_amp(5000), rnd_amp(5000), 3, "R8 after change");
    idle(); drain();

    // R9 deactivate then reactivate: first sample at phase 0
    set_cfg(1'b1, 2'b01, 26'd3000000);
    set_cfg(1'b1, 2'b10, 26'd3000000);
    send(3000, 0, 1, "R9 phase restarts at zero");
    send(3000, 0, 3, "R9 second sample");
    idle(); drain();

    // R10 saturation at 45 degrees
    set_cfg(1'b0, 2'b10, '0);
    set_cfg(1'b1, 2'b10, 26'd1 << 23);
    send(8191, 8191, 1, "R10 phase zero full scale");
    send(8191, 8191, 3, "R10 saturate high");
    send(-8192, -8192, 3, "R10 saturate low");
    idle(); drain();

    // R1 stall: held result stays frozen and input is blocked
    ready_mode = 2;
    set_cfg(1'b0, 2'b00, '0);
    send(-4321, 2468, 0, "R1 stalled item");
    idle();
    repeat (6) @(negedge clk);
    #2;
    check("R1 valid while held", int'(out_valid), 1, 0);
    check("R1 in_ready low while held", int'(in_ready), 0, 0);
    check("R1 held out_i", int'(out_i), -4321, 0);
    repeat (3) @(negedge clk);
    #2;
    check("R1 still held out_q", int'(out_q), 2468, 0);
    ready_mode = 0;
    drain();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule